// File: doc/BRIEF.md
# Mailbox Abort and Dead-State Controller

This controller runs beside a mailbox transfer engine and owns recovery of the mailbox. When reset is released it issues an abort on its own, which resynchronises the mailbox before anything else uses it. After that it issues an abort each time the engine reports a failed exchange. Each abort is one write strobe to the control register. The controller then waits a fixed poll interval, reads the status view, and repeats until it sees the mailbox idle and free of errors. If a deadline passes first, the abort has failed and the mailbox is declared dead.

The dead state is sticky, and only a full reset clears it. While the mailbox is dead, every submission is refused and every abort request fails at once, with no register access. An external cancel input forces the dead state and cuts short any abort that is in progress. Every abort request is answered by exactly one result pulse, and the abort issued at reset gets one as well. The mailbox counts as brought up only if that first abort succeeds.

The deadline is `TIMEOUT_CYCLES` clock cycles. The poll interval is P = `TIMEOUT_CYCLES`/`POLL_DIV` cycles, with a minimum of 1, and `POLL_DIV` defaults to 128.

Top module: `mbx_recovery_ctrl`

## Requirements
- R1: During reset all outputs are 0. In the first cycle after reset is released, `ctrl_abort_o` pulses high for one cycle, and this is the only abort write until the next request. `up_o` rises once this first abort succeeds.
- R2: The first status read (`stat_rd_o` high) occurs P+1 cycles after the abort write. Each following read occurs P+1 cycles after the previous one.
- R3: A read that sees `stat_busy_i`=0 and `stat_err_i`=0 ends the abort: `done_o` pulses in the next cycle and no further read occurs.
- R4: A read that happens at least `TIMEOUT_CYCLES` cycles after the abort write, and that does not see a clean status, ends the abort: `fail_o` pulses in the next cycle and `dead_o` goes high in the same cycle. With P=2 and `TIMEOUT_CYCLES`=256, exactly 86 reads occur.
- R5: If the abort issued at reset fails, `up_o` stays 0 and `dead_o` is 1.
- R6: While `dead_o` is 1, an `abort_req_i` pulse produces `fail_o` one cycle later, with no abort write and no status read.
- R7: `cancel_i` sets `dead_o` one cycle later. If an abort is in progress, `fail_o` pulses in that same cycle and no further read occurs.
- R8: Once `dead_o` is set it stays set until reset, and requests made after a cancel keep failing.
- R9: A `submit_i` pulse produces exactly one of `submit_grant_o` or `submit_reject_o` one cycle later. Grant requires that the mailbox is up, not dead and not recovering; in every other case the submission is rejected.
- R10: `done_o` and `fail_o` are never high together. An `abort_req_i` that arrives while an abort is running is merged into it: there is no second write and no second result.
- R11: A status with `stat_err_i`=1 and `stat_busy_i`=0 is not a success, and polling continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| abort_req_i | input | 1 | Abort request pulse from the transfer engine |
| cancel_i | input | 1 | Cancel request: forces dead and ends waits |
| submit_i | input | 1 | New submission request pulse |
| stat_busy_i | input | 1 | Busy bit of the status view |
| stat_err_i | input | 1 | Error bit of the status view |
| ctrl_abort_o | output | 1 | Write strobe of the abort bit to the control register |
| stat_rd_o | output | 1 | Status read strobe (poll) |
| done_o | output | 1 | Abort succeeded (pulse) |
| fail_o | output | 1 | Abort failed (pulse) |
| dead_o | output | 1 | Sticky dead flag |
| up_o | output | 1 | Mailbox brought up by a successful reset abort |
| submit_grant_o | output | 1 | Submission accepted (pulse) |
| submit_reject_o | output | 1 | Submission refused with an I/O error (pulse) |

## Verification
The hardest situation to reach from the ports is a cancel that lands in the middle of a running abort, between two polls. To get there, the stimulus holds busy high so that the abort keeps polling. It waits until two reads have been seen and then pulses cancel in a poll-interval wait. A second hard case is the timeout path, which needs a status that never clears across the whole deadline. The bench drives the reset abort and a later requested abort into that state, and it counts every read up to the failing one.

// File: rtl/mbx_rcv_pkg.sv
package mbx_rcv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_POLL  = 2'd3
  } rcv_state_e;
endpackage

// File: rtl/mbx_rcv_timer.sv
module mbx_rcv_timer #(
  parameter int unsigned TIMEOUT_CYCLES = 100_000_000,
  parameter int unsigned POLL_CYCLES    = 781_250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic active_i,
  input  logic wait_en_i,
  output logic wait_done_o,
  output logic deadline_o
);
  localparam int unsigned WW = $clog2(POLL_CYCLES + 1);
  localparam int unsigned EW = $clog2(TIMEOUT_CYCLES + POLL_CYCLES + 3);
  localparam logic [WW-1:0] WLAST = WW'(POLL_CYCLES - 1);
  localparam logic [EW-1:0] ELIM  = EW'(TIMEOUT_CYCLES);

  logic [WW-1:0] wcnt_q;
  logic [EW-1:0] elapsed_q;

  assign wait_done_o = wait_en_i && (wcnt_q == WLAST);
  assign deadline_o  = elapsed_q >= ELIM;

  // interval counter: runs only while waiting between polls
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           wcnt_q <= '0;
    else if (!wait_en_i)   wcnt_q <= '0;
    else if (wait_done_o)  wcnt_q <= '0;
    else                   wcnt_q <= wcnt_q + 1'b1;
  end

  // deadline counter: cycles since the abort write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                elapsed_q <= '0;
    else if (start_i)                           elapsed_q <= EW'(1);
    else if (active_i && (elapsed_q != '1))     elapsed_q <= elapsed_q + 1'b1;
  end

  p_wait_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_en_i && !wait_done_o |=> wait_en_i |-> (wcnt_q != '0));
endmodule

// File: rtl/mbx_rcv_flags.sv
module mbx_rcv_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cancel_i,
  input  logic kill_i,
  input  logic init_ok_i,
  output logic dead_o,
  output logic cancelled_o,
  output logic up_o
);
  logic dead_q, cancel_q, up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dead_q   <= 1'b0;
      cancel_q <= 1'b0;
      up_q     <= 1'b0;
    end else begin
      dead_q   <= dead_q | cancel_i | kill_i;
      cancel_q <= cancel_q | cancel_i;
      up_q     <= up_q | init_ok_i;
    end
  end

  assign dead_o      = dead_q;
  assign cancelled_o = cancel_q;
  assign up_o        = up_q;

  p_dead_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dead_o |=> dead_o);
  p_cancel_sets_dead_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_i |=> dead_o && cancelled_o);
endmodule

// File: rtl/mbx_rcv_gate.sv
module mbx_rcv_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic submit_i,
  input  logic up_i,
  input  logic dead_i,
  input  logic cancel_i,
  input  logic idle_i,
  output logic grant_o,
  output logic reject_o
);
  logic ok;
  logic grant_q, reject_q;

  assign ok = up_i && !dead_i && !cancel_i && idle_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q  <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      grant_q  <= submit_i && ok;
      reject_q <= submit_i && !ok;
    end
  end

  assign grant_o  = grant_q;
  assign reject_o = reject_q;

  p_one_answer_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    submit_i |=> grant_o ^ reject_o);
  p_grant_alive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> up_i && !dead_i);
endmodule

// File: rtl/mbx_rcv_fsm.sv
module mbx_rcv_fsm
  import mbx_rcv_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       abort_req_i,
  input  logic       cancel_i,
  input  logic       cancelled_i,
  input  logic       dead_i,
  input  logic       stat_busy_i,
  input  logic       stat_err_i,
  input  logic       wait_done_i,
  input  logic       deadline_i,
  output rcv_state_e state_o,
  output logic       ctrl_abort_o,
  output logic       stat_rd_o,
  output logic       done_o,
  output logic       fail_o,
  output logic       kill_o,
  output logic       init_ok_o
);
  rcv_state_e state_q, state_d;
  logic init_pend_q, init_pend_d;
  logic is_init_q, is_init_d;
  logic done_q, done_d, fail_q, fail_d;
  logic blocked, clean;

  assign blocked = dead_i | cancelled_i | cancel_i;
  assign clean   = !stat_busy_i && !stat_err_i;

  always_comb begin
    state_d     = state_q;
    init_pend_d = init_pend_q;
    is_init_d   = is_init_q;
    done_d      = 1'b0;
    fail_d      = 1'b0;
    kill_o      = 1'b0;
    init_ok_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (blocked) begin
          fail_d      = abort_req_i;
          init_pend_d = 1'b0;
        end else if (init_pend_q || abort_req_i) begin
          state_d     = ST_ISSUE;
          is_init_d   = init_pend_q;
          init_pend_d = 1'b0;
        end
      end
      ST_ISSUE: begin
        if (blocked) begin
          fail_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (blocked) begin
          fail_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (wait_done_i) begin
          state_d = ST_POLL;
        end
      end
      ST_POLL: begin
        if (blocked) begin
          fail_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (clean) begin
          done_d    = 1'b1;
          init_ok_o = is_init_q;
          state_d   = ST_IDLE;
        end else if (deadline_i) begin
          fail_d  = 1'b1;
          kill_o  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_WAIT;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      init_pend_q <= 1'b1;
      is_init_q   <= 1'b0;
      done_q      <= 1'b0;
      fail_q      <= 1'b0;
    end else begin
      state_q     <= state_d;
      init_pend_q <= init_pend_d;
      is_init_q   <= is_init_d;
      done_q      <= done_d;
      fail_q      <= fail_d;
    end
  end

  assign state_o      = state_q;
  assign ctrl_abort_o = (state_q == ST_ISSUE);
  assign stat_rd_o    = (state_q == ST_POLL);
  assign done_o       = done_q;
  assign fail_o       = fail_q;

  p_result_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));
  p_done_after_clean_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(stat_rd_o && !stat_busy_i && !stat_err_i));
  p_err_not_success_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_o && stat_err_i |=> !done_o);
  p_no_read_after_cancel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_i |=> !stat_rd_o && !ctrl_abort_o);
endmodule

// File: rtl/mbx_recovery_ctrl.sv
module mbx_recovery_ctrl
  import mbx_rcv_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 100_000_000,
  parameter int unsigned POLL_DIV       = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic abort_req_i,
  input  logic cancel_i,
  input  logic submit_i,
  input  logic stat_busy_i,
  input  logic stat_err_i,
  output logic ctrl_abort_o,
  output logic stat_rd_o,
  output logic done_o,
  output logic fail_o,
  output logic dead_o,
  output logic up_o,
  output logic submit_grant_o,
  output logic submit_reject_o
);
  localparam int unsigned POLL_RAW    = TIMEOUT_CYCLES / POLL_DIV;
  localparam int unsigned POLL_CYCLES = (POLL_RAW == 0) ? 1 : POLL_RAW;

  rcv_state_e state;
  logic wait_done, deadline, kill, init_ok, cancelled;

  mbx_rcv_fsm i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .abort_req_i  (abort_req_i),
    .cancel_i     (cancel_i),
    .cancelled_i  (cancelled),
    .dead_i       (dead_o),
    .stat_busy_i  (stat_busy_i),
    .stat_err_i   (stat_err_i),
    .wait_done_i  (wait_done),
    .deadline_i   (deadline),
    .state_o      (state),
    .ctrl_abort_o (ctrl_abort_o),
    .stat_rd_o    (stat_rd_o),
    .done_o       (done_o),
    .fail_o       (fail_o),
    .kill_o       (kill),
    .init_ok_o    (init_ok)
  );

  mbx_rcv_timer #(
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
    .POLL_CYCLES    (POLL_CYCLES)
  ) i_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (state == ST_ISSUE),
    .active_i    ((state == ST_WAIT) || (state == ST_POLL)),
    .wait_en_i   (state == ST_WAIT),
    .wait_done_o (wait_done),
    .deadline_o  (deadline)
  );

  mbx_rcv_flags i_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cancel_i    (cancel_i),
    .kill_i      (kill),
    .init_ok_i   (init_ok),
    .dead_o      (dead_o),
    .cancelled_o (cancelled),
    .up_o        (up_o)
  );

  mbx_rcv_gate i_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .submit_i (submit_i),
    .up_i     (up_o),
    .dead_i   (dead_o),
    .cancel_i (cancel_i),
    .idle_i   (state == ST_IDLE),
    .grant_o  (submit_grant_o),
    .reject_o (submit_reject_o)
  );

  p_no_access_dead_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dead_o |-> !ctrl_abort_o && !stat_rd_o);
  p_fail_dead_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !$past(cancel_i) && !$past(dead_o) |-> dead_o || $past(state) != ST_POLL);
endmodule

// File: tb/test_mbx_recovery_ctrl.sv
module test_mbx_recovery_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TMO  = 256;
  localparam int NRD_TMO = 86;

  typedef struct {
    bit    ok;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic abort_req_i = 1'b0, cancel_i = 1'b0, submit_i = 1'b0;
  logic stat_busy_i = 1'b0, stat_err_i = 1'b0;
  logic ctrl_abort_o, stat_rd_o, done_o, fail_o, dead_o, up_o;
  logic submit_grant_o, submit_reject_o;

  int n_checks = 0, n_fail = 0;
  int cyc = 0, n_wr = 0, n_rd = 0, n_res = 0;
  int wr_cyc = 0, rd_cyc = 0, res_cyc = 0;
  int rd_q[$];
  exp_t exp_q[$];
  bit finished = 1'b0;

  mbx_recovery_ctrl #(.TIMEOUT_CYCLES(TMO), .POLL_DIV(128)) i_mbx_recovery_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .abort_req_i(abort_req_i), .cancel_i(cancel_i),
    .submit_i(submit_i), .stat_busy_i(stat_busy_i), .stat_err_i(stat_err_i),
    .ctrl_abort_o(ctrl_abort_o), .stat_rd_o(stat_rd_o), .done_o(done_o),
    .fail_o(fail_o), .dead_o(dead_o), .up_o(up_o),
    .submit_grant_o(submit_grant_o), .submit_reject_o(submit_reject_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // monitor and scoreboard
  always @(negedge clk) begin
    exp_t e;
    if (rst_ni) begin
      if (ctrl_abort_o) begin n_wr++; wr_cyc = cyc; end
      if (stat_rd_o) begin n_rd++; rd_cyc = cyc; rd_q.push_back(cyc); end
      if (done_o || fail_o) begin
        n_res++;
        res_cyc = cyc;
        n_checks++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R10: unexpected result done=%0d fail=%0d", done_o, fail_o);
        end else begin
          e = exp_q.pop_front();
          if (done_o != e.ok || fail_o == e.ok) begin
            n_fail++;
            $display("FAIL %s: result done=%0d expected done=%0d", e.tag, done_o, e.ok);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(bit ok, string tag);
    exp_t e;
    e.ok = ok;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic do_reset(bit busy, bit err);
    @(negedge clk);
    rst_ni = 1'b0;
    stat_busy_i = busy;
    stat_err_i = err;
    abort_req_i = 0; cancel_i = 0; submit_i = 0;
    tick(2);
    check({ctrl_abort_o, stat_rd_o, done_o, fail_o, dead_o, up_o,
           submit_grant_o, submit_reject_o} == 8'h00, "R1 reset outputs",
          {ctrl_abort_o, stat_rd_o, done_o, fail_o, dead_o, up_o}, 0);
    n_wr = 0; n_rd = 0; n_res = 0;
    rd_q.delete();
    rst_ni = 1'b1;
  endtask

  task automatic wait_res(int limit, string tag);
    int start = n_res;
    for (int i = 0; i < limit && n_res == start; i++) tick(1);
    tick(1);
    check(n_res != start, tag, n_res - start, 1);
  endtask

  task automatic pulse_abort();
    abort_req_i = 1'b1;
    @(negedge clk);
    abort_req_i = 1'b0;
  endtask

  task automatic submit_expect(bit grant, string tag);
    submit_i = 1'b1;
    @(negedge clk);
    submit_i = 1'b0;
    check(submit_grant_o == grant && submit_reject_o == !grant, tag, submit_grant_o, grant);
  endtask

  initial begin
    int base_rd, base_wr, base_res;

    // reset abort with delayed success
    do_reset(1'b1, 1'b0);
    submit_expect(1'b0, "R9 reject before up");
    for (int i = 0; i < 50 && n_rd < 2; i++) tick(1);
    check(n_wr == 1, "R1 single reset abort write", n_wr, 1);
    check(rd_q[0] - wr_cyc == 3, "R2 first poll spacing", rd_q[0] - wr_cyc, 3);
    check(rd_q[1] - rd_q[0] == 3, "R2 poll interval", rd_q[1] - rd_q[0], 3);
    stat_busy_i = 1'b0;
    push(1'b1, "R3 reset abort done");
    wait_res(20, "R3 result seen");
    check(res_cyc - rd_cyc == 1, "R3 done one cycle after clean poll", res_cyc - rd_cyc, 1);
    check(up_o == 1'b1, "R1 up after reset abort", up_o, 1);
    base_rd = n_rd;
    tick(10);
    check(n_rd == base_rd, "R3 no poll after done", n_rd, base_rd);
    submit_expect(1'b1, "R9 grant when up");

    // error-only status keeps polling, merged request
    stat_err_i = 1'b1;
    base_rd = n_rd; base_wr = n_wr; base_res = n_res;
    pulse_abort();
    submit_expect(1'b0, "R9 reject while recovering");
    pulse_abort();
    for (int i = 0; i < 50 && n_rd < base_rd + 4; i++) tick(1);
    check(n_res == base_res, "R11 error status not success", n_res - base_res, 0);
    stat_err_i = 1'b0;
    push(1'b1, "R11 done after error clears");
    wait_res(20, "R11 result seen");
    tick(10);
    check(n_wr - base_wr == 1, "R10 merged request single write", n_wr - base_wr, 1);
    check(n_res - base_res == 1, "R10 merged request single result", n_res - base_res, 1);

    // timeout
    stat_busy_i = 1'b1;
    base_rd = n_rd;
    push(1'b0, "R4 timeout fail");
    pulse_abort();
    wait_res(400, "R4 result seen");
    check(n_rd - base_rd == NRD_TMO, "R4 poll count to deadline", n_rd - base_rd, NRD_TMO);
    check(res_cyc - rd_cyc == 1, "R4 fail one cycle after last poll", res_cyc - rd_cyc, 1);
    check(dead_o == 1'b1, "R4 dead after timeout", dead_o, 1);

    // dead behaviour
    base_rd = n_rd; base_wr = n_wr;
    push(1'b0, "R6 abort while dead");
    pulse_abort();
    check(fail_o == 1'b1, "R6 immediate fail while dead", fail_o, 1);
    tick(6);
    check(n_wr == base_wr && n_rd == base_rd, "R6 no access while dead",
          n_wr - base_wr + n_rd - base_rd, 0);
    submit_expect(1'b0, "R6 submit rejected while dead");
    tick(50);
    check(dead_o == 1'b1, "R8 dead sticky", dead_o, 1);

    // reset abort that times out
    do_reset(1'b1, 1'b0);
    push(1'b0, "R5 reset abort fail");
    wait_res(400, "R5 result seen");
    check(n_rd == NRD_TMO, "R5 poll count", n_rd, NRD_TMO);
    check(up_o == 1'b0, "R5 not brought up", up_o, 0);
    check(dead_o == 1'b1, "R5 dead", dead_o, 1);

    // quick reset abort, then cancel in a wait
    do_reset(1'b0, 1'b0);
    push(1'b1, "R3 quick reset abort");
    wait_res(20, "R3 quick result seen");
    check(res_cyc - wr_cyc == 4, "R3 done at first poll", res_cyc - wr_cyc, 4);
    stat_busy_i = 1'b1;
    base_rd = n_rd;
    push(1'b0, "R7 cancel ends abort");
    pulse_abort();
    for (int i = 0; i < 50 && n_rd < base_rd + 2; i++) tick(1);
    tick(1);
    cancel_i = 1'b1;
    @(negedge clk);
    cancel_i = 1'b0;
    check(fail_o == 1'b1, "R7 fail one cycle after cancel", fail_o, 1);
    check(dead_o == 1'b1, "R7 dead one cycle after cancel", dead_o, 1);
    tick(1);
    base_rd = n_rd; base_wr = n_wr;
    stat_busy_i = 1'b0;
    tick(20);
    check(n_rd == base_rd, "R7 no poll after cancel", n_rd, base_rd);
    push(1'b0, "R8 abort after cancel");
    pulse_abort();
    check(fail_o == 1'b1, "R8 fail after cancel", fail_o, 1);
    tick(4);
    check(n_wr == base_wr, "R8 no write after cancel", n_wr, base_wr);
    check(exp_q.size() == 0, "R10 all results seen", exp_q.size(), 0);

    finish_run();
  end
endmodule